// File: doc/BRIEF.md
# Enable-Gated 8-Bit ALU Result Stage

This block is the result end of a small 8-bit arithmetic and logic unit. A 4-bit operation code is decoded into a set of enable lines. Each of the three result sources is gated by its own enable before all of them are OR-combined onto a single result bus:

- a bitwise logic unit covering OR, XOR, AND, AND-NOT and pass-through;
- a carry-chain adder covering add and subtract;
- an external input port.

An operation that enables no source therefore yields zero. One inversion line on the second operand serves two operations. For subtract it complements the operand and also feeds the adder's carry-in. For AND-NOT it complements the operand into the AND gate.

The merged result, the adder carry-out and a zero flag are captured in output registers. They appear one clock after the operands and code are presented. The block holds no other state: the output register is its only storage, loaded every cycle, and there is no sequencing between operations.

Top module: `alu8_result_stage`

## Requirements
- R1: Operation codes are 4 bits: OR=0, XOR=1, AND=2, ANDN=3, ADD=4, SUB=5, PASS=6, IN=7, CLEAR=8. For OR, XOR and AND the result is the named bitwise function of `src_a` and `src_b`.
- R2: ANDN (code 3) gives `src_a & ~src_b`.
- R3: ADD (code 4) gives `(src_a + src_b) mod 256`, and `carry_out` is bit 8 of the full sum.
- R4: SUB (code 5) gives `src_a + ~src_b + 1` mod 256, and `carry_out` is bit 8 of that sum, so it is 1 exactly when `src_a >= src_b`.
- R5: PASS (code 6) gives `src_b` unchanged, whatever `src_a` holds.
- R6: IN (code 7) gives `in_port`, whatever `src_a` and `src_b` hold. The `in_port` value has no effect on any other code.
- R7: CLEAR (code 8) and the unused codes 9 to 15 give a result of zero and a `carry_out` of 0.
- R8: `zero_flag` is 1 exactly when the registered result is all zeros.
- R9: `carry_out` is 0 for every code other than ADD and SUB.
- R10: Outputs are registered. Values presented before a rising clock edge appear after that edge and not before it. While `rst_n` is low, `result` is 0, `carry_out` is 0 and `zero_flag` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; outputs update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_code | input | 4 | Operation code (encoding given in R1) |
| src_a | input | 8 | First operand |
| src_b | input | 8 | Second operand, optionally inverted |
| in_port | input | 8 | External input port value |
| result | output | 8 | Registered merged result bus |
| carry_out | output | 1 | Registered adder carry-out, 0 for non-arithmetic codes |
| zero_flag | output | 1 | Registered flag, 1 when `result` is zero |

## Verification
The output register is the only state, so any internal fault shows at the ports exactly one clock after the offending inputs.

Each fault has a recognisable signature:
- A decoder line raised for the wrong code ORs a second source onto the bus. The visible result is then a superset of the expected bits.
- A missing enable drops bits.
- A wrong carry-in offsets a subtract by exactly one.

The vector table is chosen so that each of these fault signatures yields a value different from the correct one. In each case `zero_flag` must still agree with the visible result in the same cycle.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_OR    = 4'd0,
        OP_XOR   = 4'd1,
        OP_AND   = 4'd2,
        OP_ANDN  = 4'd3,
        OP_ADD   = 4'd4,
        OP_SUB   = 4'd5,
        OP_PASS  = 4'd6,
        OP_IN    = 4'd7,
        OP_CLEAR = 4'd8
    } alu_op_e;

    // Control lines produced by the decoder
    typedef struct packed {
        logic inv_b;     // complement second operand (also adder carry-in)
        logic fwd_b;     // forward second operand through logic unit
        logic and_on;    // AND term enable
        logic xor_sel;   // OR/XOR term chooses XOR
        logic orx_on;    // OR/XOR term enable
        logic logic_on;  // logic unit drives the bus
        logic sum_on;    // adder drives the bus
        logic port_on;   // input port drives the bus
    } alu_ctl_t;

    localparam alu_ctl_t CTL_NONE = '0;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
    import alu8_pkg::*;
(
    input  logic [OP_W-1:0] op_code,
    output alu_ctl_t        ctl
);

    always_comb begin
        ctl = CTL_NONE;
        unique case (op_code)
            OP_OR:   begin ctl.orx_on = 1'b1; ctl.logic_on = 1'b1; end
            OP_XOR:  begin ctl.orx_on = 1'b1; ctl.xor_sel = 1'b1; ctl.logic_on = 1'b1; end
            OP_AND:  begin ctl.and_on = 1'b1; ctl.logic_on = 1'b1; end
            OP_ANDN: begin ctl.and_on = 1'b1; ctl.inv_b = 1'b1; ctl.logic_on = 1'b1; end
            OP_ADD:  begin ctl.sum_on = 1'b1; end
            OP_SUB:  begin ctl.sum_on = 1'b1; ctl.inv_b = 1'b1; end
            OP_PASS: begin ctl.fwd_b = 1'b1; ctl.logic_on = 1'b1; end
            OP_IN:   begin ctl.port_on = 1'b1; end
            default: ctl = CTL_NONE;   // CLEAR and unused codes (R7)
        endcase
    end

    // At most one source may drive the bus (R6, R7)
    always_comb begin
        p_one_source_r6: assert ($onehot0({ctl.logic_on, ctl.sum_on, ctl.port_on}))
            else $error("decoder enabled more than one source");
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b_mod,   // second operand after optional inversion
    input  alu_ctl_t     ctl,
    output logic [W-1:0] y
);

    logic [W-1:0] orx_term;
    logic [W-1:0] and_term;
    logic [W-1:0] fwd_term;

    always_comb begin
        orx_term = ctl.xor_sel ? (a ^ b_mod) : (a | b_mod);
        orx_term = orx_term & {W{ctl.orx_on}};
        and_term = (a & b_mod) & {W{ctl.and_on}};
        fwd_term = b_mod & {W{ctl.fwd_b}};
        y        = orx_term | and_term | fwd_term;
    end

endmodule

// File: rtl/alu8_adder.sv
module alu8_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b_mod,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    localparam int NC = W + 1;

    logic [NC-1:0] c;
    logic [W-1:0]  gen;
    logic [W-1:0]  prop;

    assign c[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign gen[i]  = a[i] & b_mod[i];
        assign prop[i] = a[i] ^ b_mod[i];
        assign c[i+1]  = gen[i] | (prop[i] & c[i]);
        assign sum[i]  = prop[i] ^ c[i];
    end

    assign cout = c[W];

endmodule

// File: rtl/alu8_merge.sv
module alu8_merge #(
    parameter int W = 8
) (
    input  logic [W-1:0] logic_y,
    input  logic [W-1:0] sum_y,
    input  logic [W-1:0] port_y,
    input  logic         sum_c,
    input  logic         logic_on,
    input  logic         sum_on,
    input  logic         port_on,
    output logic [W-1:0] bus,
    output logic         carry,
    output logic         zero
);

    always_comb begin
        bus   = (logic_y & {W{logic_on}})
              | (sum_y   & {W{sum_on}})
              | (port_y  & {W{port_on}});
        carry = sum_c & sum_on;
        zero  = ~|bus;
    end

endmodule

// File: rtl/alu8_result_stage.sv
module alu8_result_stage
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] op_code,
    input  logic [W-1:0]    src_a,
    input  logic [W-1:0]    src_b,
    input  logic [W-1:0]    in_port,
    output logic [W-1:0]    result,
    output logic            carry_out,
    output logic            zero_flag
);

    alu_ctl_t     ctl;
    logic [W-1:0] b_mod;
    logic [W-1:0] logic_y;
    logic [W-1:0] sum_y;
    logic         sum_c;
    logic [W-1:0] bus_d;
    logic         carry_d;
    logic         zero_d;

    alu8_decode u_decode (
        .op_code (op_code),
        .ctl     (ctl)
    );

    // Shared inversion serves SUB and ANDN
    assign b_mod = src_b ^ {W{ctl.inv_b}};

    alu8_logic #(.W(W)) u_logic (
        .a     (src_a),
        .b_mod (b_mod),
        .ctl   (ctl),
        .y     (logic_y)
    );

    alu8_adder #(.W(W)) u_adder (
        .a     (src_a),
        .b_mod (b_mod),
        .cin   (ctl.inv_b),
        .sum   (sum_y),
        .cout  (sum_c)
    );

    alu8_merge #(.W(W)) u_merge (
        .logic_y  (logic_y),
        .sum_y    (sum_y),
        .port_y   (in_port),
        .sum_c    (sum_c),
        .logic_on (ctl.logic_on),
        .sum_on   (ctl.sum_on),
        .port_on  (ctl.port_on),
        .bus      (bus_d),
        .carry    (carry_d),
        .zero     (zero_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result    <= '0;
            carry_out <= 1'b0;
            zero_flag <= 1'b1;
        end else begin
            result    <= bus_d;
            carry_out <= carry_d;
            zero_flag <= zero_d;
        end
    end

    p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        zero_flag == (result == '0))
        else $error("zero flag disagrees with result");

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code >= OP_CLEAR) |=> (result == '0 && !carry_out))
        else $error("clear or unused code produced nonzero output");

    p_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_PASS) |=> (result == $past(src_b)))
        else $error("pass did not forward second operand");

    p_in_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_IN) |=> (result == $past(in_port)))
        else $error("input port not selected");

    p_no_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code != OP_ADD && op_code != OP_SUB) |=> !carry_out)
        else $error("carry set for non-arithmetic code");

    p_andn_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_ANDN) |=> (result == ($past(src_a) & ~$past(src_b))))
        else $error("and-not result wrong");

endmodule

// File: tb/alu8_result_stage_tb.sv
module alu8_result_stage_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_code = 4'd0;
    logic [7:0] src_a = 8'd0;
    logic [7:0] src_b = 8'd0;
    logic [7:0] in_port = 8'd0;
    logic [7:0] result;
    logic       carry_out;
    logic       zero_flag;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    alu8_result_stage u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_code   (op_code),
        .src_a     (src_a),
        .src_b     (src_b),
        .in_port   (in_port),
        .result    (result),
        .carry_out (carry_out),
        .zero_flag (zero_flag)
    );

    // {op, a, b, port}
    localparam int NV = 20;
    localparam logic [27:0] VEC [NV] = '{
        {4'd0, 8'h0F, 8'hF0, 8'hFF},  // R1 OR
        {4'd1, 8'hAA, 8'hFF, 8'h00},  // R1 XOR
        {4'd1, 8'h55, 8'h55, 8'hFF},  // R1 XOR to zero, port ignored
        {4'd2, 8'h3C, 8'h0F, 8'hFF},  // R1 AND
        {4'd3, 8'hFF, 8'h0F, 8'h00},  // R2 ANDN
        {4'd3, 8'h0F, 8'hFF, 8'h00},  // R2 ANDN to zero
        {4'd4, 8'h7F, 8'h01, 8'h00},  // R3 ADD
        {4'd4, 8'hFF, 8'h01, 8'h00},  // R3 ADD wrap, carry
        {4'd4, 8'h80, 8'h80, 8'hAA},  // R3 ADD carry
        {4'd5, 8'h05, 8'h03, 8'h00},  // R4 SUB
        {4'd5, 8'h03, 8'h05, 8'h00},  // R4 SUB borrow
        {4'd5, 8'h42, 8'h42, 8'h00},  // R4 SUB equal
        {4'd6, 8'hFF, 8'h5A, 8'h00},  // R5 PASS
        {4'd6, 8'hFF, 8'h00, 8'hFF},  // R5 PASS zero
        {4'd7, 8'hFF, 8'hFF, 8'hC3},  // R6 IN
        {4'd7, 8'hFF, 8'hFF, 8'h00},  // R6 IN zero
        {4'd8, 8'hFF, 8'hFF, 8'hFF},  // R7 CLEAR
        {4'd9, 8'hFF, 8'h01, 8'hFF},  // R7 unused
        {4'd15, 8'h80, 8'h80, 8'hFF}, // R7 unused
        {4'd2, 8'hF0, 8'h0F, 8'hFF}   // R1 AND disjoint
    };

    function automatic logic [8:0] model(input logic [3:0] op, input logic [7:0] a,
                                         input logic [7:0] b, input logic [7:0] p);
        logic [8:0] s;
        case (op)
            4'd0: model = {1'b0, a | b};
            4'd1: model = {1'b0, a ^ b};
            4'd2: model = {1'b0, a & b};
            4'd3: model = {1'b0, a & ~b};
            4'd4: model = {1'b0, a} + {1'b0, b};
            4'd5: begin
                s = {1'b0, a} + {1'b0, ~b} + 9'd1;
                model = s;
            end
            4'd6: model = {1'b0, b};
            4'd7: model = {1'b0, p};
            default: model = 9'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1, 4'd2: tag_of = "R1";
            4'd3: tag_of = "R2";
            4'd4: tag_of = "R3";
            4'd5: tag_of = "R4";
            4'd6: tag_of = "R5";
            4'd7: tag_of = "R6";
            default: tag_of = "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] exp_r,
                         input logic exp_c, input logic exp_z);
        n_checks++;
        if (result !== exp_r || carry_out !== exp_c || zero_flag !== exp_z) begin
            n_fails++;
            $display("FAIL %s: got result=%h carry=%b zero=%b, expected result=%h carry=%b zero=%b",
                     tag, result, carry_out, zero_flag, exp_r, exp_c, exp_z);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        logic [8:0] e;
        // R10 reset state
        repeat (2) @(negedge clk);
        check("R10 reset", 8'h00, 1'b0, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (VEC[i]) begin
            op_code = VEC[i][27:24];
            src_a   = VEC[i][23:16];
            src_b   = VEC[i][15:8];
            in_port = VEC[i][7:0];
            @(negedge clk);
            e = model(op_code, src_a, src_b, in_port);
            check(tag_of(op_code), e[7:0], e[8], e[7:0] == 8'h00);
            // R9: carry only for ADD and SUB
            if (op_code != 4'd4 && op_code != 4'd5)
                check("R9 carry", e[7:0], 1'b0, e[7:0] == 8'h00);
            // R8: zero flag follows visible result
            check("R8 zero", e[7:0], e[8], e[7:0] == 8'h00);
        end

        // R10 latency: new inputs do not show before the edge
        op_code = 4'd4; src_a = 8'h10; src_b = 8'h20; in_port = 8'h00;
        @(negedge clk);
        check("R10 load", 8'h30, 1'b0, 1'b0);
        op_code = 4'd7; in_port = 8'h99;
        #1;
        check("R10 hold", 8'h30, 1'b0, 1'b0);
        @(negedge clk);
        check("R10 update", 8'h99, 1'b0, 1'b0);

        // R6: port change under a non-IN code has no effect
        op_code = 4'd0; src_a = 8'h01; src_b = 8'h02; in_port = 8'hF0;
        @(negedge clk);
        check("R6 port ignored", 8'h03, 1'b0, 1'b0);

        // R10 asynchronous reset mid-run
        op_code = 4'd4; src_a = 8'hFF; src_b = 8'hFF;
        @(negedge clk);
        check("R3 carry before reset", 8'hFE, 1'b1, 1'b0);
        rst_n = 1'b0;
        #1;
        check("R10 async reset", 8'h00, 1'b0, 1'b1);
        @(negedge clk);
        check("R10 held in reset", 8'h00, 1'b0, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 after reset", 8'hFE, 1'b1, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule